// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block sits beside a PCI-to-PCI bridge's configuration space and turns its coarse base and limit fields into full 64-bit forwarding windows for three address spaces: I/O, non-prefetchable memory and prefetchable memory. Each window end is built from a field whose upper bits carry the address and whose low nibble carries a capability code. When bit 0 of that nibble is set, an extension register supplies the high part of the address.

A request carries an address and a two-bit space kind. The block selects the window that matches the kind and compares the address against it. One cycle later it returns the selected base, the selected limit and a hit flag, which tells the bridge whether to forward the transaction.

Requests enter on a valid/ready port and results leave on a valid/ready port, through a single register stage. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. A result stays on `rsp_*` unchanged until the cycle where `rsp_ready` is high. The configuration fields are sampled in the cycle a request is accepted.

Top module: `win_decoder`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: I/O base: bits 15:12 = base field bits 7:4, bits 11:0 = 0, bits 31:16 = I/O base extension when base field bit 0 is 1 (otherwise 0), bits 63:32 = 0. Field bits 3:1 have no effect.
- R3: I/O limit: built the same way from the limit field and the I/O limit extension (gated by the limit field's own bit 0), with bits 11:0 forced to all ones.
- R4: Non-prefetchable memory: base bits 31:20 = field bits 15:4, all other bits 0. The limit is built the same way from its field, with bits 19:0 forced to all ones. Field bits 3:0 have no effect.
- R5: Prefetchable memory: built as in R4 from its own fields, plus bits 63:32 = the 32-bit extension when that end's field bit 0 is 1 (otherwise 0). Field bits 3:1 have no effect.
- R6: Kind bit 0 set selects I/O regardless of bit 1. Otherwise kind bit 1 set selects prefetchable memory. Kind 0 selects non-prefetchable memory.
- R7: `rsp_hit` is 1 exactly when base <= address <= limit, compared as unsigned 64-bit values. A window whose base is above its limit never hits.
- R8: A request accepted at one clock edge appears on `rsp_*` with `rsp_valid` = 1 right after the next edge. Its result is computed from the configuration present at acceptance.
- R9: `req_ready` = !`rsp_valid` or `rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, all `rsp_*` outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_base_fld | input | 8 | I/O base field (address bits 7:4, capability 3:0) |
| io_limit_fld | input | 8 | I/O limit field |
| io_base_ext | input | 16 | I/O base bits 31:16 |
| io_limit_ext | input | 16 | I/O limit bits 31:16 |
| mem_base_fld | input | 16 | Memory base field |
| mem_limit_fld | input | 16 | Memory limit field |
| pf_base_fld | input | 16 | Prefetchable base field |
| pf_limit_fld | input | 16 | Prefetchable limit field |
| pf_base_ext | input | 32 | Prefetchable base bits 63:32 |
| pf_limit_ext | input | 32 | Prefetchable limit bits 63:32 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 64 | Request address |
| req_kind | input | 2 | Bit 0: I/O space, bit 1: prefetchable |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes result when high |
| rsp_base | output | 64 | Selected window base |
| rsp_limit | output | 64 | Selected window limit |
| rsp_hit | output | 1 | Address lies inside the window |

## Verification
The hardest situation to reach is a stalled result whose configuration changes underneath it. The result must keep the window captured at acceptance while the fields now describe another window. The bench holds `rsp_ready` low for several cycles, rewrites every field during the stall and checks that the outputs stay frozen. It also drives addresses exactly at base, at limit and one step outside each, and it covers inverted windows and capability nibbles that have bits 3:1 set while bit 0 is clear.

// File: rtl/win_pkg.sv
package win_pkg;

  localparam int unsigned KIND_IO_BIT = 0;
  localparam int unsigned KIND_PF_BIT = 1;

  typedef enum logic [1:0] {
    WIN_MEM  = 2'd0,
    WIN_IO   = 2'd1,
    WIN_PREF = 2'd2
  } win_sel_e;

  // I/O outranks prefetchable, which outranks plain memory
  function automatic win_sel_e pick_window(input logic [1:0] kind);
    if (kind[KIND_IO_BIT])      return WIN_IO;
    else if (kind[KIND_PF_BIT]) return WIN_PREF;
    else                        return WIN_MEM;
  endfunction

endpackage

// File: rtl/win_field_expand.sv
module win_field_expand #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned FLD_W   = 16,
  parameter int unsigned CAP_W   = 4,
  parameter int unsigned GRAN    = 20,
  parameter int unsigned EXT_W   = 32,
  parameter bit          HAS_EXT = 1'b0,
  parameter bit          PAD     = 1'b0
) (
  input  logic [FLD_W-1:0]  fld,
  input  logic [EXT_W-1:0]  ext,
  output logic [ADDR_W-1:0] addr
);

  localparam int unsigned CORE_W  = FLD_W - CAP_W;
  localparam int unsigned EXT_LSB = GRAN + CORE_W;

  logic unused_cap;
  assign unused_cap = ^fld[CAP_W-1:1];

  always_comb begin
    addr = '0;
    addr[GRAN-1:0] = {GRAN{PAD}};
    addr[GRAN +: CORE_W] = fld[FLD_W-1:CAP_W];
    if (HAS_EXT && fld[0]) begin
      addr[EXT_LSB +: EXT_W] = ext;
    end
  end

endmodule

// File: rtl/win_range_check.sv
module win_range_check #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              hit
);

  logic above_base;
  logic below_limit;

  assign above_base  = (addr >= base);
  assign below_limit = (addr <= limit);
  assign hit         = above_base && below_limit;

endmodule

// File: rtl/win_stage.sv
module win_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= in_data;
    end
  end

  // R8
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/win_decoder.sv
module win_decoder #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned CAP_W     = 4,
  parameter int unsigned IO_FLD_W  = 8,
  parameter int unsigned IO_EXT_W  = 16,
  parameter int unsigned IO_GRAN   = 12,
  parameter int unsigned MEM_FLD_W = 16,
  parameter int unsigned MEM_GRAN  = 20,
  parameter int unsigned PF_EXT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IO_FLD_W-1:0]  io_base_fld,
  input  logic [IO_FLD_W-1:0]  io_limit_fld,
  input  logic [IO_EXT_W-1:0]  io_base_ext,
  input  logic [IO_EXT_W-1:0]  io_limit_ext,
  input  logic [MEM_FLD_W-1:0] mem_base_fld,
  input  logic [MEM_FLD_W-1:0] mem_limit_fld,
  input  logic [MEM_FLD_W-1:0] pf_base_fld,
  input  logic [MEM_FLD_W-1:0] pf_limit_fld,
  input  logic [PF_EXT_W-1:0]  pf_base_ext,
  input  logic [PF_EXT_W-1:0]  pf_limit_ext,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_kind,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [ADDR_W-1:0]    rsp_base,
  output logic [ADDR_W-1:0]    rsp_limit,
  output logic                 rsp_hit
);

  import win_pkg::*;

  localparam int unsigned NUM_ENDS = 2;
  localparam int unsigned PAY_W    = 2 * ADDR_W + 1;

  logic [IO_FLD_W-1:0]  io_fld  [NUM_ENDS];
  logic [IO_EXT_W-1:0]  io_ext  [NUM_ENDS];
  logic [MEM_FLD_W-1:0] mem_fld [NUM_ENDS];
  logic [MEM_FLD_W-1:0] pf_fld  [NUM_ENDS];
  logic [PF_EXT_W-1:0]  pf_ext  [NUM_ENDS];
  logic [0:0]           no_ext;

  logic [ADDR_W-1:0] io_end  [NUM_ENDS];
  logic [ADDR_W-1:0] mem_end [NUM_ENDS];
  logic [ADDR_W-1:0] pf_end  [NUM_ENDS];

  assign io_fld[0]  = io_base_fld;
  assign io_fld[1]  = io_limit_fld;
  assign io_ext[0]  = io_base_ext;
  assign io_ext[1]  = io_limit_ext;
  assign mem_fld[0] = mem_base_fld;
  assign mem_fld[1] = mem_limit_fld;
  assign pf_fld[0]  = pf_base_fld;
  assign pf_fld[1]  = pf_limit_fld;
  assign pf_ext[0]  = pf_base_ext;
  assign pf_ext[1]  = pf_limit_ext;
  assign no_ext     = 1'b0;

  // end 0 is the base, end 1 the limit (padded with ones)
  for (genvar e = 0; e < NUM_ENDS; e++) begin : g_end
    win_field_expand #(
      .ADDR_W(ADDR_W), .FLD_W(IO_FLD_W), .CAP_W(CAP_W), .GRAN(IO_GRAN),
      .EXT_W(IO_EXT_W), .HAS_EXT(1'b1), .PAD(e == 1)
    ) u_io (
      .fld(io_fld[e]), .ext(io_ext[e]), .addr(io_end[e])
    );

    win_field_expand #(
      .ADDR_W(ADDR_W), .FLD_W(MEM_FLD_W), .CAP_W(CAP_W), .GRAN(MEM_GRAN),
      .EXT_W(1), .HAS_EXT(1'b0), .PAD(e == 1)
    ) u_mem (
      .fld(mem_fld[e]), .ext(no_ext), .addr(mem_end[e])
    );

    win_field_expand #(
      .ADDR_W(ADDR_W), .FLD_W(MEM_FLD_W), .CAP_W(CAP_W), .GRAN(MEM_GRAN),
      .EXT_W(PF_EXT_W), .HAS_EXT(1'b1), .PAD(e == 1)
    ) u_pf (
      .fld(pf_fld[e]), .ext(pf_ext[e]), .addr(pf_end[e])
    );
  end

  win_sel_e          sel;
  logic [ADDR_W-1:0] sel_base;
  logic [ADDR_W-1:0] sel_limit;
  logic              sel_hit;

  assign sel = pick_window(req_kind);

  always_comb begin
    unique case (sel)
      WIN_IO: begin
        sel_base  = io_end[0];
        sel_limit = io_end[1];
      end
      WIN_PREF: begin
        sel_base  = pf_end[0];
        sel_limit = pf_end[1];
      end
      default: begin
        sel_base  = mem_end[0];
        sel_limit = mem_end[1];
      end
    endcase
  end

  win_range_check #(.ADDR_W(ADDR_W)) u_cmp (
    .addr(req_addr), .base(sel_base), .limit(sel_limit), .hit(sel_hit)
  );

  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  assign pay_in = {sel_base, sel_limit, sel_hit};

  win_stage #(.DATA_W(PAY_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_in),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pay_out)
  );

  assign {rsp_base, rsp_limit, rsp_hit} = pay_out;

  // R7
  hit_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_base <= rsp_limit);

  // R3
  limit_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> &rsp_limit[IO_GRAN-1:0]);

  // R2
  base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_base[IO_GRAN-1:0] == '0);

endmodule

// File: tb/tb_win_decoder.sv
module tb_win_decoder;

  typedef struct {
    logic [7:0]  iob, iol;
    logic [15:0] iobx, iolx;
    logic [15:0] mb, ml, pb, pl;
    logic [31:0] pbx, plx;
  } cfg_t;

  typedef struct {
    longint unsigned b, l;
    bit              h;
    bit [1:0]        k;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  cfg_t cur, nxt;
  logic        req_valid = 0, req_ready, rsp_valid, rsp_ready = 1, rsp_hit;
  logic [63:0] req_addr = 0, rsp_base, rsp_limit;
  logic [1:0]  req_kind = 0;

  int checks = 0, fails = 0;
  exp_t exp_q[$];
  bit hold_pending = 0;
  logic [63:0] h_base, h_limit;
  logic        h_hit;

  always #5 clk = ~clk;

  win_decoder dut (
    .clk(clk), .rst_n(rst_n),
    .io_base_fld(cur.iob), .io_limit_fld(cur.iol),
    .io_base_ext(cur.iobx), .io_limit_ext(cur.iolx),
    .mem_base_fld(cur.mb), .mem_limit_fld(cur.ml),
    .pf_base_fld(cur.pb), .pf_limit_fld(cur.pl),
    .pf_base_ext(cur.pbx), .pf_limit_ext(cur.plx),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_base(rsp_base), .rsp_limit(rsp_limit), .rsp_hit(rsp_hit)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural window model
  function automatic void ref_win(cfg_t c, bit [1:0] k,
                                  output longint unsigned b, output longint unsigned l);
    if (k[0]) begin
      b = longint'(c.iob >> 4) * 64'd4096;
      if (c.iob[0]) b = b + longint'(c.iobx) * 64'd65536;
      l = longint'(c.iol >> 4) * 64'd4096 + 64'd4095;
      if (c.iol[0]) l = l + longint'(c.iolx) * 64'd65536;
    end else if (k[1]) begin
      b = longint'(c.pb >> 4) * 64'd1048576;
      if (c.pb[0]) b = b + longint'(c.pbx) * 64'h1_0000_0000;
      l = longint'(c.pl >> 4) * 64'd1048576 + 64'd1048575;
      if (c.pl[0]) l = l + longint'(c.plx) * 64'h1_0000_0000;
    end else begin
      b = longint'(c.mb >> 4) * 64'd1048576;
      l = longint'(c.ml >> 4) * 64'd1048576 + 64'd1048575;
    end
  endfunction

  task automatic evaluate();
    exp_t e;
    string bt, lt;
    if (hold_pending) begin
      chk("R9", "held valid", {63'd0, rsp_valid}, 64'd1);
      chk("R9", "held base", rsp_base, h_base);
      chk("R9", "held limit", rsp_limit, h_limit);
      chk("R9", "held hit", {63'd0, rsp_hit}, {63'd0, h_hit});
    end
    chk("R8", "rsp_valid timing", {63'd0, rsp_valid}, {63'd0, exp_q.size() != 0});
    chk("R9", "req_ready", {63'd0, req_ready}, {63'd0, (!rsp_valid || rsp_ready)});
    if (rsp_valid && rsp_ready && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      bt = e.k[0] ? "R2 R6" : (e.k[1] ? "R5 R6" : "R4 R6");
      lt = e.k[0] ? "R3 R6" : (e.k[1] ? "R5 R6" : "R4 R6");
      chk(bt, "base", rsp_base, e.b);
      chk(lt, "limit", rsp_limit, e.l);
      chk("R7", "hit", {63'd0, rsp_hit}, {63'd0, e.h});
    end
    hold_pending = rsp_valid && !rsp_ready;
    h_base = rsp_base; h_limit = rsp_limit; h_hit = rsp_hit;
    if (req_valid && req_ready) begin
      ref_win(cur, req_kind, e.b, e.l);
      e.k = req_kind;
      e.h = (req_addr >= e.b) && (req_addr <= e.l);
      exp_q.push_back(e);
    end
  endtask

  task automatic step(bit v, logic [63:0] a, logic [1:0] k, bit rr);
    @(negedge clk);
    cur = nxt;
    req_valid = v; req_addr = a; req_kind = k; rsp_ready = rr;
    #1;
    evaluate();
  endtask

  task automatic req(logic [63:0] a, logic [1:0] k);
    step(1'b1, a, k, 1'b1);
  endtask

  function automatic logic [63:0] pick_addr(bit [1:0] k);
    longint unsigned b, l;
    ref_win(nxt, k, b, l);
    case ($urandom_range(0, 5))
      0: return b;
      1: return l;
      2: return b - 1;
      3: return l + 1;
      4: return b + longint'($urandom_range(0, 4095));
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    nxt = '{iob: 8'h21, iol: 8'h31, iobx: 16'h0001, iolx: 16'h0001,
            mb: 16'h1230, ml: 16'h1240, pb: 16'h4001, pl: 16'h4001,
            pbx: 32'h2, plx: 32'h2};
    cur = nxt;
    repeat (3) step(1'b0, 64'd0, 2'd0, 1'b1);
    // R1 reset state
    chk("R1", "rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    chk("R1", "req_ready in reset", {63'd0, req_ready}, 64'd1);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    chk("R1", "req_ready after reset", {63'd0, req_ready}, 64'd1);

    // R2 R3 I/O window with extensions: 0x1_2000..0x1_3FFF
    req(64'h1_2000, 2'd1); req(64'h1_3FFF, 2'd1);
    req(64'h1_1FFF, 2'd1); req(64'h1_4000, 2'd1);
    // R6 both bits set selects I/O
    req(64'h1_2800, 2'd3);
    // R2 capability bits 3:1 without bit 0: extension ignored
    nxt.iob = 8'h2E; nxt.iol = 8'h3E; nxt.iobx = 16'hBEEF; nxt.iolx = 16'hBEEF;
    req(64'h2000, 2'd1); req(64'hBEEF_2000, 2'd1);
    // R4 memory window 0x1230_0000..0x124F_FFFF
    req(64'h1230_0000, 2'd0); req(64'h124F_FFFF, 2'd0);
    req(64'h122F_FFFF, 2'd0); req(64'h1250_0000, 2'd0);
    // R5 prefetchable 64-bit window
    req(64'h2_4000_0000, 2'd2); req(64'h2_400F_FFFF, 2'd2);
    req(64'h2_4010_0000, 2'd2); req(64'h4000_0000, 2'd2);
    nxt.pb = 16'h400E; nxt.pl = 16'h400F;
    req(64'h4000_0000, 2'd2);
    // R7 inverted window never hits
    nxt.mb = 16'h5000; nxt.ml = 16'h4000;
    req(64'h4500_0000, 2'd0); req(64'h5000_0000, 2'd0); req(64'h400F_FFFF, 2'd0);
    // R9 stall while configuration changes, R8 capture at acceptance
    step(1'b1, 64'h1230_0000, 2'd0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      nxt.mb = 16'(i * 16'h1110); nxt.ml = 16'hFFF0;
      step(1'b1, 64'h9999_0000, 2'd0, 1'b0);
    end
    step(1'b0, 64'd0, 2'd0, 1'b1);
    step(1'b0, 64'd0, 2'd0, 1'b1);

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      bit [1:0] k;
      if ($urandom_range(0, 7) == 0) begin
        nxt.iob = 8'($urandom); nxt.iol = 8'($urandom);
        nxt.iobx = 16'($urandom); nxt.iolx = 16'($urandom);
        nxt.mb = 16'($urandom); nxt.ml = 16'($urandom);
        nxt.pb = 16'($urandom); nxt.pl = 16'($urandom);
        nxt.pbx = $urandom_range(0, 3); nxt.plx = $urandom_range(0, 3);
      end
      k = 2'($urandom);
      step($urandom_range(0, 3) != 0, pick_addr(k), k, $urandom_range(0, 3) != 0);
    end
    step(1'b0, 64'd0, 2'd0, 1'b1);
    step(1'b0, 64'd0, 2'd0, 1'b1);

    summary();
    $finish;
  end

endmodule